// File: doc/BRIEF.md
# Slew-Limited Voltage Code Sequencer

This block drives the 6-bit reference code of a step-down regulator. The code sets the output voltage as 0.6 V plus 12.5 mV per step, so codes 0 to 63 span 0.6 V to 1.3875 V. Two setting registers each supply an enable bit and a code. A select pin picks which register is live. When the live register's enable bit is clear, the target becomes code 0 and the block reports the output as off.

Upward moves of the target are walked one code at a time. The wait between steps is a base tick count shifted left by a 3-bit rate code, so each rate code is half as fast as the one before it. With the default base of 10 cycles at 64 MHz, this gives 80 mV/µs at rate 0 down to 0.625 mV/µs at rate 7. Downward moves write the new code at once and raise a switching-inhibit flag. The flag holds until an external comparator reports that the output has fallen to the new level.

If the target rises again while the inhibit is up, the inhibit drops and stepping starts from the present code. If the target changes during a climb, the climb carries on toward the new value without restarting the step wait.

Top module: `vref_seq_top`

## Requirements
- R1: With `vsel_pin` low the target is the code from setting 0; with it high the target is the code from setting 1.
- R2: When the live setting's enable bit is 0 the target is code 0, and `out_en` shows the live enable bit one clock edge after it changes.
- R3: While the target is above the code, the code rises by exactly 1 per step. The k-th step lands on the (k × BASE_TICKS × 2^slew_sel)-th clock edge, counted from the first edge that sees the target above the code.
- R4: Each `slew_sel` value, encoded 0 to 7, doubles the step interval of the value below it; slew 2 gives 40 cycles and slew 7 gives 1280 cycles at the default base.
- R5: On the first edge that sees the target below the code, the code takes the target value and `sw_inhibit` goes to 1.
- R6: `sw_inhibit` stays 1 while the code is unchanged and `out_at_tgt` is 0. It clears on the first edge that sees `out_at_tgt` at 1, and the code cannot rise while it is set.
- R7: A target above the code while `sw_inhibit` is set clears the inhibit on the next edge, and stepping starts from the current code with a full interval.
- R8: Raising the target during a climb keeps the running step wait, so the next step keeps its original timing.
- R9: `done` is 1 exactly when the code equals the target and `sw_inhibit` is 0; it follows the inputs in the same cycle.
- R10: After reset the code is 0, `out_en` is 0 and `sw_inhibit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg0_en | input | 1 | Setting 0 enable bit |
| cfg0_code | input | 6 | Setting 0 voltage code |
| cfg1_en | input | 1 | Setting 1 enable bit |
| cfg1_code | input | 6 | Setting 1 voltage code |
| slew_sel | input | 3 | Rise rate code, 0 fastest, 7 slowest |
| vsel_pin | input | 1 | Setting select, 0 picks setting 0 |
| out_at_tgt | input | 1 | Comparator flag: output at or below the reference |
| vcode | output | 6 | Reference code driven to the regulator |
| out_en | output | 1 | Regulator enabled |
| sw_inhibit | output | 1 | Switching held off during a descent |
| done | output | 1 | Code settled at the target |

## Verification
Drops, inhibit set and clear, and `out_en` all change on the first clock edge after the stimulus. `done` follows its inputs in the same cycle. A rise step lands on the edge numbered by a whole multiple of the interval. The bench drives and samples on falling edges, counting edges from the stimulus. For each step it checks the code one edge before the step is due and again on the due edge, so a step that comes early or late is caught. The retarget case changes the target partway through a wait and checks that the next step keeps its original edge.

// File: rtl/vref_pkg.sv
package vref_pkg;

    localparam int VC_W = 6;

    typedef struct packed {
        logic            en;
        logic [VC_W-1:0] code;
    } cfg_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_t;

    function automatic dir_t classify(input logic [VC_W-1:0] tgt,
                                      input logic [VC_W-1:0] cur);
        if (tgt > cur)      return DIR_UP;
        else if (tgt < cur) return DIR_DOWN;
        else                return DIR_HOLD;
    endfunction

endpackage

// File: rtl/vref_target_sel.sv
module vref_target_sel
    import vref_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cfg_t            cfg0,
    input  cfg_t            cfg1,
    input  logic            vsel,
    output logic [VC_W-1:0] tgt,
    output logic            en_q
);
    cfg_t live;

    always_comb begin
        live = vsel ? cfg1 : cfg0;
        tgt  = live.en ? live.code : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= live.en;
    end

    AST_EN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> en_q == $past(live.en)); // R2

endmodule

// File: rtl/vref_step_timer.sv
module vref_step_timer #(
    parameter int BASE_TICKS = 10,
    parameter int SLEW_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [SLEW_W-1:0] slew,
    output logic              tick
);
    localparam int MAX_IVL = BASE_TICKS << ((1 << SLEW_W) - 1);
    localparam int CNT_W   = $clog2(MAX_IVL + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ivl;

    always_comb begin
        ivl  = CNT_W'(BASE_TICKS) << slew;
        tick = run && (cnt >= (ivl - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> cnt == '0); // R3

endmodule

// File: rtl/vref_ramp_core.sv
module vref_ramp_core
    import vref_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [VC_W-1:0] tgt,
    input  logic            tick,
    input  logic            cmp_ok,
    output logic            run,
    output logic [VC_W-1:0] code,
    output logic            inh,
    output logic            done
);
    dir_t dir;

    always_comb begin
        dir  = classify(tgt, code);
        run  = (dir == DIR_UP);
        done = (dir == DIR_HOLD) && !inh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            inh  <= 1'b0;
        end else begin
            case (dir)
                DIR_DOWN: begin
                    code <= tgt;
                    inh  <= 1'b1;
                end
                DIR_UP: begin
                    inh <= 1'b0;
                    if (tick) code <= code + 1'b1;
                end
                default: begin
                    if (inh && cmp_ok) inh <= 1'b0;
                end
            endcase
        end
    end

    AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
        code > $past(code) |-> code == $past(code) + 1'b1); // R3

    AST_FALL_SET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && ($past(tgt) < $past(code)) |-> inh && code == $past(tgt)); // R5

    AST_NO_RISE_INH: assert property (@(posedge clk) disable iff (rst)
        inh |-> code <= $past(code)); // R6

    AST_INH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(inh) |-> $past(cmp_ok) || ($past(tgt) > $past(code))); // R7

endmodule

// File: rtl/vref_seq_top.sv
module vref_seq_top
    import vref_pkg::*;
#(
    parameter int BASE_TICKS = 10,
    parameter int SLEW_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg0_en,
    input  logic [VC_W-1:0]   cfg0_code,
    input  logic              cfg1_en,
    input  logic [VC_W-1:0]   cfg1_code,
    input  logic [SLEW_W-1:0] slew_sel,
    input  logic              vsel_pin,
    input  logic              out_at_tgt,
    output logic [VC_W-1:0]   vcode,
    output logic              out_en,
    output logic              sw_inhibit,
    output logic              done
);
    cfg_t            cfg0, cfg1;
    logic [VC_W-1:0] tgt;
    logic            run, tick;

    assign cfg0 = '{en: cfg0_en, code: cfg0_code};
    assign cfg1 = '{en: cfg1_en, code: cfg1_code};

    vref_target_sel u_sel (
        .clk  (clk),
        .rst  (rst),
        .cfg0 (cfg0),
        .cfg1 (cfg1),
        .vsel (vsel_pin),
        .tgt  (tgt),
        .en_q (out_en)
    );

    vref_step_timer #(
        .BASE_TICKS (BASE_TICKS),
        .SLEW_W     (SLEW_W)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .slew (slew_sel),
        .tick (tick)
    );

    vref_ramp_core u_core (
        .clk    (clk),
        .rst    (rst),
        .tgt    (tgt),
        .tick   (tick),
        .cmp_ok (out_at_tgt),
        .run    (run),
        .code   (vcode),
        .inh    (sw_inhibit),
        .done   (done)
    );

    AST_DONE_NO_INH: assert property (@(posedge clk) disable iff (rst)
        done |-> !sw_inhibit); // R9

endmodule

// File: tb/sim_vref_seq_top.sv
module sim_vref_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg0_en = 1'b0, cfg1_en = 1'b0;
    logic [5:0] cfg0_code = '0, cfg1_code = '0;
    logic [2:0] slew_sel = '0;
    logic       vsel_pin = 1'b0;
    logic       out_at_tgt = 1'b0;
    logic [5:0] vcode;
    logic       out_en, sw_inhibit, done;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    vref_seq_top u0 (
        .clk(clk), .rst(rst),
        .cfg0_en(cfg0_en), .cfg0_code(cfg0_code),
        .cfg1_en(cfg1_en), .cfg1_code(cfg1_code),
        .slew_sel(slew_sel), .vsel_pin(vsel_pin), .out_at_tgt(out_at_tgt),
        .vcode(vcode), .out_en(out_en), .sw_inhibit(sw_inhibit), .done(done)
    );

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        edges(3);
        rst = 1'b0;
        edges(1);
        chk("R10", "code after reset", vcode, 0);
        chk("R10", "out_en after reset", out_en, 0);
        chk("R10", "inhibit after reset", sw_inhibit, 0);
        chk("R9", "done at zero target", done, 1);
    endtask

    task automatic t_enable_rise;
        cfg0_code = 6'd5;
        edges(3);
        chk("R2", "disabled setting gives code 0", vcode, 0);
        chk("R2", "out_en while disabled", out_en, 0);
        cfg0_en = 1'b1;
        edges(1);
        chk("R2", "out_en one edge after enable", out_en, 1);
        chk("R9", "done low while climbing", done, 0);
        edges(8);
        chk("R3", "no step before edge 10", vcode, 0);
        edges(1);
        chk("R3", "first step at edge 10", vcode, 1);
        edges(9);
        chk("R3", "no second step at edge 19", vcode, 1);
        edges(1);
        chk("R3", "second step at edge 20", vcode, 2);
        edges(30);
        chk("R3", "code reaches target", vcode, 5);
        chk("R9", "done at target", done, 1);
    endtask

    task automatic t_fall;
        cfg0_code = 6'd2;
        edges(1);
        chk("R5", "code drops at once", vcode, 2);
        chk("R5", "inhibit set on drop", sw_inhibit, 1);
        chk("R9", "done low under inhibit", done, 0);
        edges(5);
        chk("R6", "inhibit held, comparator low", sw_inhibit, 1);
        out_at_tgt = 1'b1;
        edges(1);
        chk("R6", "inhibit clears on comparator", sw_inhibit, 0);
        chk("R6", "code held on clear", vcode, 2);
        chk("R9", "done after clear", done, 1);
        out_at_tgt = 1'b0;
    endtask

    task automatic t_select;
        cfg1_en = 1'b1;
        cfg1_code = 6'd1;
        edges(2);
        chk("R1", "select low ignores setting 1", vcode, 2);
        vsel_pin = 1'b1;
        edges(1);
        chk("R1", "select high uses setting 1", vcode, 1);
        out_at_tgt = 1'b1;
        edges(1);
        out_at_tgt = 1'b0;
        chk("R6", "inhibit cleared after select drop", sw_inhibit, 0);
        vsel_pin = 1'b0;
        edges(9);
        chk("R1", "back on setting 0, not yet stepped", vcode, 1);
        edges(1);
        chk("R1", "back on setting 0 stepped", vcode, 2);
    endtask

    task automatic t_reclimb;
        cfg0_code = 6'd0;
        edges(1);
        chk("R5", "drop to zero", vcode, 0);
        chk("R5", "inhibit on drop to zero", sw_inhibit, 1);
        cfg0_code = 6'd3;
        edges(1);
        chk("R7", "inhibit cleared by rising target", sw_inhibit, 0);
        chk("R7", "code still current", vcode, 0);
        edges(8);
        chk("R7", "no step before full interval", vcode, 0);
        edges(1);
        chk("R7", "step from current code", vcode, 1);
        edges(20);
        chk("R7", "reclimb reaches target", vcode, 3);
    endtask

    task automatic t_retarget;
        cfg0_code = 6'd5;
        edges(15);
        chk("R8", "one step into climb", vcode, 4);
        cfg0_code = 6'd7;
        edges(4);
        chk("R8", "wait kept, no early step", vcode, 4);
        edges(1);
        chk("R8", "step on original edge", vcode, 5);
        edges(20);
        chk("R8", "reaches new target", vcode, 7);
    endtask

    task automatic t_slew;
        slew_sel = 3'd2;
        cfg0_code = 6'd8;
        edges(39);
        chk("R4", "slew 2 no step at 39", vcode, 7);
        edges(1);
        chk("R4", "slew 2 step at 40", vcode, 8);
        slew_sel = 3'd7;
        cfg0_code = 6'd9;
        edges(1279);
        chk("R4", "slew 7 no step at 1279", vcode, 8);
        edges(1);
        chk("R4", "slew 7 step at 1280", vcode, 9);
    endtask

    task automatic t_disable;
        cfg0_en = 1'b0;
        edges(1);
        chk("R2", "disable drops code to 0", vcode, 0);
        chk("R2", "out_en low after disable", out_en, 0);
        chk("R5", "inhibit on disable drop", sw_inhibit, 1);
    endtask

    initial begin
        t_reset();
        t_enable_rise();
        t_fall();
        t_select();
        t_reclimb();
        t_retarget();
        t_slew();
        t_disable();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule